// File: doc/BRIEF.md
# Two-Rank Converter Code Register

This block is the digital front end of a 12-bit digital-to-analog converter. A host writes a converter code into a first-rank holding register. The holding register has two sections, an 8-bit low section and a 4-bit high section, and each section has its own load enable. A transfer strobe copies the whole 12-bit holding word into a second-rank output register. That output register alone drives the code seen by the converter, so a partly written code never reaches the analog side.

The host bus can be 8 or 16 bits wide, chosen by a select input. On a narrow bus the code is right-justified. The low eight bits arrive in one access, and the upper four bits arrive on data lines 3..0 in a second access. On a wide bus all twelve bits sit on data lines 11..0, and both sections can be loaded together.

When a load and the transfer strobe are raised in the same cycle, the new data goes straight through to the output, so the final write needs no separate transfer access. An asynchronous active-low reset sets both ranks to the offset-binary mid-scale code 12'h800, which is the bipolar-zero output.

Top module: `dacin_frontend`

## Requirements
- R1: While `rstN` is low, `dacCode` reads 12'h800, without waiting for a clock edge, and the holding register also becomes 12'h800.
- R2: A clock edge with `loadLo` or `loadHi` high but `xfer` low leaves `dacCode` unchanged.
- R3: With `busWide` = 0, `loadLo` stores `dataIn[7:0]` into holding bits 7..0.
- R4: With `busWide` = 0, `loadHi` stores `dataIn[3:0]` into holding bits 11..8.
- R5: With `busWide` = 1, `loadLo` stores `dataIn[7:0]` into bits 7..0 and `loadHi` stores `dataIn[11:8]` into bits 11..8. Raising both loads the full word in one edge.
- R6: An edge with `xfer` high and a load high places the newly loaded data into `dacCode` at that same edge.
- R7: An edge with `xfer` high and no load copies the held word into `dacCode`. After reset this gives 12'h800.
- R8: Data lines outside the selected lanes have no effect: `dataIn[15:12]` in either mode, and `dataIn[15:4]` for a high-section load on the narrow bus.
- R9: `dacCode` changes only at a clock edge where `xfer` is high, or through reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset to mid-scale |
| busWide | input | 1 | 1 = 16-bit bus lanes, 0 = 8-bit right-justified lanes |
| dataIn | input | 16 | Host data bus |
| loadLo | input | 1 | Load enable for holding bits 7..0 |
| loadHi | input | 1 | Load enable for holding bits 11..8 |
| xfer | input | 1 | Copy the holding word (including this edge's loads) to the output |
| dacCode | output | 12 | Converter code from the output rank |

## Verification
Loads and transfers change `dacCode` at the rising edge where they are sampled. The bench therefore drives each stimulus at a falling edge, advances its reference model at the next rising edge, and compares 1 ns later. Loads without a transfer show up only at a later transfer, so every holding-register check is made through a following transfer. Reset acts without a clock, so the bench lowers `rstN` between edges and checks mid-scale before the next rising edge.

// File: rtl/dacin_pkg.sv
package dacin_pkg;
  // Strobes sent from the gating control to the register datapath
  typedef struct packed {
    logic wrByte;      // write low section
    logic wrNib;       // write high section
    logic nibHighLane; // high section taken from the wide-bus lane
    logic copyOut;     // copy holding word to output rank
  } dacStrobe_t;
endpackage

// File: rtl/dacin_ctrl.sv
module dacin_ctrl
  import dacin_pkg::*;
(
  input  logic       busWide,
  input  logic       loadLo,
  input  logic       loadHi,
  input  logic       xfer,
  output dacStrobe_t strobe
);
  always_comb begin
    strobe.wrByte      = loadLo;
    strobe.wrNib       = loadHi;
    strobe.nibHighLane = busWide;
    strobe.copyOut     = xfer;
  end
endmodule

// File: rtl/dacin_datapath.sv
module dacin_datapath
  import dacin_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] laneData,
  input  dacStrobe_t        strobe,
  output logic [CODE_W-1:0] outCode
);
  localparam int NIB_W = CODE_W - BYTE_W;
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [BYTE_W-1:0] byteReg, byteNext;
  logic [NIB_W-1:0]  nibReg, nibNext, nibLane;

  // Narrow bus brings the high section right-justified; wide bus in place
  always_comb begin
    nibLane  = strobe.nibHighLane ? laneData[BYTE_W +: NIB_W] : laneData[NIB_W-1:0];
    byteNext = strobe.wrByte ? laneData[BYTE_W-1:0] : byteReg;
    nibNext  = strobe.wrNib ? nibLane : nibReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteReg <= MID_CODE[BYTE_W-1:0];
      nibReg  <= MID_CODE[CODE_W-1:BYTE_W];
    end else begin
      byteReg <= byteNext;
      nibReg  <= nibNext;
    end
  end

  // Output rank sees this edge's loads, so write and transfer share an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                outCode <= MID_CODE;
    else if (strobe.copyOut)  outCode <= {nibNext, byteNext};
  end
endmodule

// File: rtl/dacin_frontend.sv
module dacin_frontend
  import dacin_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BYTE_W = 8,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWide,
  input  logic [BUS_W-1:0]  dataIn,
  input  logic              loadLo,
  input  logic              loadHi,
  input  logic              xfer,
  output logic [CODE_W-1:0] dacCode
);
  dacStrobe_t strobe;
  logic       unusedLines;

  assign unusedLines = ^dataIn[BUS_W-1:CODE_W];

  dacin_ctrl u_ctrl (
    .busWide(busWide),
    .loadLo (loadLo),
    .loadHi (loadHi),
    .xfer   (xfer),
    .strobe (strobe)
  );

  dacin_datapath #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .laneData(dataIn[CODE_W-1:0]),
    .strobe  (strobe),
    .outCode (dacCode)
  );
endmodule

// File: rtl/dacin_checker.sv
module dacin_checker #(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWide,
  input logic [BUS_W-1:0]  dataIn,
  input logic              loadLo,
  input logic              loadHi,
  input logic              xfer,
  input logic [CODE_W-1:0] dacCode
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  // R1: output held at mid-scale while reset is low
  a_r1_reset_mid: assert property (@(posedge clk) !rstN |-> dacCode == MID_CODE);

  // R2, R9: no transfer, no change
  a_r9_hold_without_xfer: assert property (@(posedge clk) disable iff (!rstN)
    !xfer |=> $stable(dacCode));

  // R6, R3: narrow low-section write passes through with the transfer
  a_r6_lo_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && loadLo) |=> dacCode[7:0] == $past(dataIn[7:0]));

  // R4: narrow high-section write comes from lines 3..0
  a_r4_narrow_nibble: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && loadHi && !busWide) |=> dacCode[CODE_W-1:8] == $past(dataIn[3:0]));

  // R5: wide full-word write with transfer
  a_r5_wide_word: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && loadHi && loadLo && busWide) |=> dacCode == $past(dataIn[CODE_W-1:0]));
endmodule

bind dacin_frontend dacin_checker #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWide(busWide), .dataIn(dataIn),
  .loadLo(loadLo), .loadHi(loadHi), .xfer(xfer), .dacCode(dacCode)
);

// File: tb/tb_dacin_frontend.sv
`timescale 1ns/1ps
module tb_dacin_frontend;
  logic        clk = 0;
  logic        rstN = 1;
  logic        busWide = 0;
  logic [15:0] dataIn = '0;
  logic        loadLo = 0, loadHi = 0, xfer = 0;
  logic [11:0] dacCode;

  int checks = 0, errors = 0;
  int refIn = 'h800, refOut = 'h800;
  bit finished = 0;

  always #4 clk = ~clk;

  dacin_frontend dut (
    .clk(clk), .rstN(rstN), .busWide(busWide), .dataIn(dataIn),
    .loadLo(loadLo), .loadHi(loadHi), .xfer(xfer), .dacCode(dacCode)
  );

  task automatic check(input string tag, input int expv);
    checks++;
    if (int'(dacCode) != expv) begin
      errors++;
      $display("FAIL %s: dacCode=%03h expected=%03h", tag, dacCode, expv[11:0]);
    end
  endtask

  // Drive at falling edge, update reference at rising edge, compare 1 ns later
  task automatic step(input string tag, input bit w, input bit lo, input bit hi,
                      input bit x, input logic [15:0] d);
    @(negedge clk);
    busWide = w; loadLo = lo; loadHi = hi; xfer = x; dataIn = d;
    @(posedge clk);
    if (lo) refIn = (refIn & 'hF00) | int'(d[7:0]);
    if (hi) refIn = (refIn & 'h0FF) | ((w ? int'(d[11:8]) : int'(d[3:0])) << 8);
    if (x)  refOut = refIn;
    #1 check(tag, refOut);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    #2 rstN = 0;
    #1 check("R1 initial reset", 'h800);
    @(negedge clk); rstN = 1;

    // Narrow bus, byte then nibble, loads only (R2) then transfer (R7, R3, R4)
    step("R2 narrow byte load", 0, 1, 0, 0, 16'h005A);
    step("R2 narrow nibble load", 0, 0, 1, 0, 16'hFFF3);
    step("R7 plain transfer R3 R4", 0, 0, 0, 1, 16'h0000);
    // Nibble then byte, byte write with transfer (R6, R8 on nibble lanes)
    step("R8 nibble ignores high lines", 0, 0, 1, 0, 16'hABCC);
    step("R6 byte with transfer", 0, 1, 0, 1, 16'h0071);
    // Byte then nibble, nibble write with transfer
    step("R2 byte load", 0, 1, 0, 0, 16'h009E);
    step("R6 nibble with transfer R4", 0, 0, 1, 1, 16'h0002);
    // Wide bus
    step("R2 wide full load", 1, 1, 1, 0, 16'hF7A5);
    step("R5 wide transfer R8", 1, 0, 0, 1, 16'h0000);
    step("R5 wide load and transfer", 1, 1, 1, 1, 16'h1234);
    step("R5 wide nibble load", 1, 0, 1, 0, 16'h0B00);
    step("R5 wide nibble transfer", 1, 0, 0, 1, 16'h0000);
    // Reset mid-sequence
    step("R2 byte before reset", 0, 1, 0, 0, 16'h0011);
    #1 rstN = 0;
    #1 check("R1 async reset mid-cycle", 'h800);
    refIn = 'h800; refOut = 'h800;
    @(negedge clk); loadLo = 0; xfer = 0;
    @(posedge clk); #1 check("R1 held in reset", 'h800);
    @(negedge clk); rstN = 1;
    step("R7 transfer after reset", 0, 0, 0, 1, 16'h0000);
    // Mixed patterns against the model
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R9 mixed", lfsr[0], lfsr[1], lfsr[2], lfsr[3] & lfsr[4], {lfsr[7:0], lfsr[15:8]});
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule